// File: doc/BRIEF.md
# Byte Arithmetic and Logic Unit with Status Flags

This block is the execution unit of a small 8-bit processor core. Each cycle it takes two byte operands and a 4-bit operation code. The operation is add, subtract or a bitwise function. Combinationally, it produces the byte result, a write-back enable for the register file, a per-flag update mask and the candidate flag values. The block holds a five-bit status register of carry, zero, negative, overflow and half-carry flags. When the `issue` strobe is high, the status register takes in the masked candidate flags on the rising clock edge.

Every operation changes only its own subset of flags, and the other flags keep their old values. The two compare operations update flags but do not request a write-back. Subtract-with-borrow and compare-with-borrow chain the zero flag, so that a comparison over several bytes reports zero only when every byte was zero. The operands come from the register file, and `issue` is a plain strobe. The unit finishes every operation in one cycle, so it has no valid/ready handshake and never exerts back-pressure.

Top module: `alu8_core`

## Requirements
- R1: `flags` bit 0 is C, bit 1 is Z, bit 2 is N, bit 3 is V and bit 4 is H. The same bit order applies to `flag_mask` and `flag_next`. All flags are 0 after reset. The opcodes are: 0 add, 1 add-with-carry, 2 subtract, 3 subtract-with-borrow, 4 AND, 5 OR, 6 XOR, 7 one's complement, 8 negate, 9 increment, 10 decrement, 11 compare, 12 compare-with-borrow, 13 load-ones, 14 AND-NOT (`opnd_a & ~opnd_b`), 15 no-operation.
- R2: Add gives `a+b`, and add-with-carry gives `a+b+C`. Both update all five flags. C is the carry out of bit 7, and H is the carry out of bit 3.
- R3: Subtract gives `a-b`, and subtract-with-borrow gives `a-b-C`. Both update all five flags. C is the borrow out of bit 7, and H is the borrow out of bit 3.
- R4: For subtract-with-borrow and compare-with-borrow, the new Z is 1 only when the difference is zero and Z was already 1.
- R5: AND, OR, XOR and AND-NOT update only Z, N and V. V becomes 0, and C and H keep their values.
- R6: One's complement gives `0xFF-a` and updates C, Z, N and V. C becomes 1, V becomes 0 and H is kept.
- R7: Negate gives `0x00-a` and updates all five flags as a subtraction from zero.
- R8: Increment gives `a+1` and decrement gives `a-1`. Both update only Z, N and V. V is 1 exactly when increment yields 0x80 or decrement yields 0x7F.
- R9: Compare and compare-with-borrow set the flags exactly as subtract and subtract-with-borrow do, with `wr_en` held low.
- R10: Load-ones gives 0xFF with `wr_en` high and changes no flag.
- R11: N is bit 7 of the result, and Z is 1 when the result is zero (subject to R4). `flags` changes only on a rising edge where `issue` is high.
- R12: No-operation has `wr_en` low and an all-zero `flag_mask`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| issue | input | 1 | Operation executes this cycle, so flags update at the edge |
| op | input | 4 | Operation code (see R1) |
| opnd_a | input | 8 | Destination / first operand |
| opnd_b | input | 8 | Source register or immediate operand |
| result | output | 8 | Operation result (combinational) |
| wr_en | output | 1 | Result should be written back |
| flag_mask | output | 5 | Flags this operation updates |
| flag_next | output | 5 | Candidate flag values |
| flags | output | 5 | Registered status flags |

## Verification
`result`, `wr_en`, `flag_mask` and `flag_next` are combinational. They are due in the same cycle that the operands and opcode are presented. `flags` is due one rising edge after an issued operation. The bench drives inputs on the falling edge and samples the combinational outputs 5 ns later, before the next rising edge. It then samples `flags` 1 ns after that rising edge and compares it with its own flag model, which it advances at the same point.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  localparam int FLAG_W = 5;
  localparam int FC = 0;
  localparam int FZ = 1;
  localparam int FN = 2;
  localparam int FV = 3;
  localparam int FH = 4;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_ADC  = 4'd1,
    OP_SUB  = 4'd2,
    OP_SBC  = 4'd3,
    OP_AND  = 4'd4,
    OP_OR   = 4'd5,
    OP_XOR  = 4'd6,
    OP_COM  = 4'd7,
    OP_NEG  = 4'd8,
    OP_INC  = 4'd9,
    OP_DEC  = 4'd10,
    OP_CP   = 4'd11,
    OP_CPC  = 4'd12,
    OP_ONES = 4'd13,
    OP_ANDN = 4'd14,
    OP_NOP  = 4'd15
  } alu_op_e;

  // second adder operand source
  typedef enum logic [1:0] {
    BSRC_B   = 2'd0,
    BSRC_ONE = 2'd1,
    BSRC_A   = 2'd2
  } bsrc_e;

  // bitwise unit functions
  typedef enum logic [2:0] {
    LF_AND  = 3'd0,
    LF_OR   = 3'd1,
    LF_XOR  = 3'd2,
    LF_ANDN = 3'd3,
    LF_COM  = 3'd4,
    LF_ONES = 3'd5
  } lfn_e;

  typedef struct packed {
    logic              is_arith;
    logic              zero_a;
    bsrc_e             bsrc;
    logic              sub;
    logic              use_c;
    logic              chain_z;
    lfn_e              lfn;
    logic              wr;
    logic [FLAG_W-1:0] mask;
  } ctrl_t;

  localparam logic [FLAG_W-1:0] M_ALL  = 5'b11111;
  localparam logic [FLAG_W-1:0] M_ZNV  = 5'b01110;
  localparam logic [FLAG_W-1:0] M_CZNV = 5'b01111;
  localparam logic [FLAG_W-1:0] M_NONE = 5'b00000;

endpackage

// File: rtl/alu8_decode.sv
module alu8_decode
  import alu8_pkg::*;
(
  input  logic [3:0] op,
  output ctrl_t      ctrl
);

  alu_op_e op_e;
  assign op_e = alu_op_e'(op);

  always_comb begin
    ctrl          = '0;
    ctrl.bsrc     = BSRC_B;
    ctrl.lfn      = LF_AND;
    ctrl.is_arith = 1'b1;
    unique case (op_e)
      OP_ADD: begin ctrl.wr = 1'b1; ctrl.mask = M_ALL; end
      OP_ADC: begin ctrl.wr = 1'b1; ctrl.mask = M_ALL; ctrl.use_c = 1'b1; end
      OP_SUB: begin ctrl.wr = 1'b1; ctrl.mask = M_ALL; ctrl.sub = 1'b1; end
      OP_SBC: begin
        ctrl.wr = 1'b1; ctrl.mask = M_ALL; ctrl.sub = 1'b1;
        ctrl.use_c = 1'b1; ctrl.chain_z = 1'b1;
      end
      OP_CP:  begin ctrl.mask = M_ALL; ctrl.sub = 1'b1; end
      OP_CPC: begin
        ctrl.mask = M_ALL; ctrl.sub = 1'b1;
        ctrl.use_c = 1'b1; ctrl.chain_z = 1'b1;
      end
      OP_NEG: begin
        ctrl.wr = 1'b1; ctrl.mask = M_ALL; ctrl.sub = 1'b1;
        ctrl.zero_a = 1'b1; ctrl.bsrc = BSRC_A;
      end
      OP_INC: begin ctrl.wr = 1'b1; ctrl.mask = M_ZNV; ctrl.bsrc = BSRC_ONE; end
      OP_DEC: begin
        ctrl.wr = 1'b1; ctrl.mask = M_ZNV; ctrl.bsrc = BSRC_ONE; ctrl.sub = 1'b1;
      end
      OP_AND:  begin ctrl.is_arith = 1'b0; ctrl.wr = 1'b1; ctrl.mask = M_ZNV;  ctrl.lfn = LF_AND;  end
      OP_OR:   begin ctrl.is_arith = 1'b0; ctrl.wr = 1'b1; ctrl.mask = M_ZNV;  ctrl.lfn = LF_OR;   end
      OP_XOR:  begin ctrl.is_arith = 1'b0; ctrl.wr = 1'b1; ctrl.mask = M_ZNV;  ctrl.lfn = LF_XOR;  end
      OP_ANDN: begin ctrl.is_arith = 1'b0; ctrl.wr = 1'b1; ctrl.mask = M_ZNV;  ctrl.lfn = LF_ANDN; end
      OP_COM:  begin ctrl.is_arith = 1'b0; ctrl.wr = 1'b1; ctrl.mask = M_CZNV; ctrl.lfn = LF_COM;  end
      OP_ONES: begin ctrl.is_arith = 1'b0; ctrl.wr = 1'b1; ctrl.mask = M_NONE; ctrl.lfn = LF_ONES; end
      default: begin ctrl.is_arith = 1'b0; ctrl.wr = 1'b0; ctrl.mask = M_NONE; end
    endcase
  end

endmodule

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
  parameter int DATA_W = 8,
  parameter int NIB_W  = 4
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              sub,
  input  logic              cin,
  output logic [DATA_W-1:0] sum,
  output logic              c_out,
  output logic              h_out,
  output logic              v_out
);

  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] b_x;
  logic              c_in_x;
  logic              c_raw;

  // subtraction is a + ~b + ~borrow_in
  assign b_x    = sub ? ~b : b;
  assign c_in_x = sub ? ~cin : cin;

  assign {c_raw, sum} = {1'b0, a} + {1'b0, b_x} + {{DATA_W{1'b0}}, c_in_x};

  // carry into bit NIB_W recovered from the sum bit
  assign h_out = (a[NIB_W] ^ b_x[NIB_W] ^ sum[NIB_W]) ^ sub;
  assign c_out = c_raw ^ sub;
  assign v_out = (a[MSB] == b_x[MSB]) && (sum[MSB] != a[MSB]);

endmodule

// File: rtl/alu8_bitwise.sv
module alu8_bitwise
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  lfn_e              fn,
  output logic [DATA_W-1:0] y
);

  always_comb begin
    unique case (fn)
      LF_AND:  y = a & b;
      LF_OR:   y = a | b;
      LF_XOR:  y = a ^ b;
      LF_ANDN: y = a & ~b;
      LF_COM:  y = ~a;
      LF_ONES: y = '1;
      default: y = '0;
    endcase
  end

endmodule

// File: rtl/alu8_flagreg.sv
module alu8_flagreg #(
  parameter int FLAG_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd,
  input  logic [FLAG_W-1:0] mask,
  input  logic [FLAG_W-1:0] nxt,
  output logic [FLAG_W-1:0] q
);

  for (genvar i = 0; i < FLAG_W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 q[i] <= 1'b0;
      else if (upd && mask[i])    q[i] <= nxt[i];
    end
  end

endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  logic [3:0]        op,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  output logic [DATA_W-1:0] result,
  output logic              wr_en,
  output logic [4:0]        flag_mask,
  output logic [4:0]        flag_next,
  output logic [4:0]        flags
);

  localparam int NIB_W = DATA_W / 2;
  localparam int MSB   = DATA_W - 1;
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  ctrl_t             ctrl;
  logic [DATA_W-1:0] add_a, add_b, add_y, bit_y;
  logic              add_c, add_h, add_v, add_cin;

  alu8_decode i_dec (.op(op), .ctrl(ctrl));

  assign add_a   = ctrl.zero_a ? '0 : opnd_a;
  assign add_cin = ctrl.use_c & flags[FC];

  always_comb begin
    unique case (ctrl.bsrc)
      BSRC_ONE: add_b = ONE;
      BSRC_A:   add_b = opnd_a;
      default:  add_b = opnd_b;
    endcase
  end

  alu8_addsub #(.DATA_W(DATA_W), .NIB_W(NIB_W)) i_add (
    .a(add_a), .b(add_b), .sub(ctrl.sub), .cin(add_cin),
    .sum(add_y), .c_out(add_c), .h_out(add_h), .v_out(add_v)
  );

  alu8_bitwise #(.DATA_W(DATA_W)) i_bit (
    .a(opnd_a), .b(opnd_b), .fn(ctrl.lfn), .y(bit_y)
  );

  assign result    = ctrl.is_arith ? add_y : bit_y;
  assign wr_en     = ctrl.wr;
  assign flag_mask = ctrl.mask;

  always_comb begin
    flag_next     = '0;
    flag_next[FZ] = (result == '0) && (!ctrl.chain_z || flags[FZ]);
    flag_next[FN] = result[MSB];
    flag_next[FC] = ctrl.is_arith ? add_c : 1'b1;
    flag_next[FV] = ctrl.is_arith & add_v;
    flag_next[FH] = add_h;
  end

  alu8_flagreg #(.FLAG_W(FLAG_W)) i_flags (
    .clk(clk), .rst_n(rst_n), .upd(issue),
    .mask(flag_mask), .nxt(flag_next), .q(flags)
  );

endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       issue,
  input logic [3:0] op,
  input logic [7:0] result,
  input logic       wr_en,
  input logic [4:0] flag_mask,
  input logic [4:0] flag_next,
  input logic [4:0] flags
);

  // R11
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !issue |=> $stable(flags));

  // R11
  n_is_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_mask[2] |-> flag_next[2] == result[7]);

  // R5
  logic_keeps_ch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue && (op == 4'd4 || op == 4'd5 || op == 4'd6 || op == 4'd14)
    |=> flags[0] == $past(flags[0]) && flags[4] == $past(flags[4]) && !flags[3]);

  // R6
  com_sets_c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue && op == 4'd7 |=> flags[0] && !flags[3]);

  // R4
  z_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue && (op == 4'd3 || op == 4'd12) && !flags[1] |=> !flags[1]);

  // R9
  cmp_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 4'd11 || op == 4'd12) |-> !wr_en);

  // R10
  ones_no_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue && op == 4'd13 |=> $stable(flags));

  // R12
  nop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op == 4'd15 |-> !wr_en && flag_mask == 5'b0);

endmodule

bind alu8_core alu8_core_chk i_chk (
  .clk(clk), .rst_n(rst_n), .issue(issue), .op(op), .result(result),
  .wr_en(wr_en), .flag_mask(flag_mask), .flag_next(flag_next), .flags(flags)
);

// File: tb/test_alu8_core.sv
module test_alu8_core;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       issue = 1'b0;
  logic [3:0] op = 4'd15;
  logic [7:0] opnd_a = '0, opnd_b = '0;
  logic [7:0] result;
  logic       wr_en;
  logic [4:0] flag_mask, flag_next, flags;

  int checks = 0;
  int errors = 0;
  logic [4:0] mflags = '0;

  always #10 clk = ~clk;

  alu8_core i_alu8_core (
    .clk(clk), .rst_n(rst_n), .issue(issue), .op(op),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .result(result), .wr_en(wr_en),
    .flag_mask(flag_mask), .flag_next(flag_next), .flags(flags)
  );

  function automatic string req_of(input logic [3:0] o);
    case (o)
      4'd0, 4'd1:               return "R2";
      4'd2:                     return "R3";
      4'd3:                     return "R3/R4";
      4'd4, 4'd5, 4'd6, 4'd14:  return "R5";
      4'd7:                     return "R6";
      4'd8:                     return "R7";
      4'd9, 4'd10:              return "R8";
      4'd11, 4'd12:             return "R9";
      4'd13:                    return "R10";
      default:                  return "R12";
    endcase
  endfunction

  function automatic int sgn(input int x);
    return (x > 127) ? x - 256 : x;
  endfunction

  // expected values from the requirements; flag bit order C,Z,N,V,H (R1)
  task automatic model(input logic [3:0] o, input int a, input int b, input logic [4:0] f,
                       output logic [7:0] res, output logic wr, output logic [4:0] m,
                       output logic [4:0] nf);
    int x, y, ci, t, s;
    logic chain;
    x = a; y = b; ci = 0; chain = 1'b0; nf = '0; wr = 1'b1; m = 5'b11111; res = '0;
    case (o)
      4'd0, 4'd1, 4'd9: begin
        if (o == 4'd1) ci = int'(f[0]);
        if (o == 4'd9) begin y = 1; m = 5'b01110; end
        t = x + y + ci; res = t[7:0];
        nf[0] = t > 255;
        nf[4] = ((x & 15) + (y & 15) + ci) > 15;
        s = sgn(x) + sgn(y) + ci; nf[3] = (s > 127) || (s < -128);
      end
      4'd2, 4'd3, 4'd8, 4'd10, 4'd11, 4'd12: begin
        if (o == 4'd3 || o == 4'd12) begin ci = int'(f[0]); chain = 1'b1; end
        if (o == 4'd8) begin x = 0; y = a; end
        if (o == 4'd10) begin y = 1; m = 5'b01110; end
        if (o == 4'd11 || o == 4'd12) wr = 1'b0;
        t = x - y - ci; res = t[7:0];
        nf[0] = t < 0;
        nf[4] = ((x & 15) - (y & 15) - ci) < 0;
        s = sgn(x) - sgn(y) - ci; nf[3] = (s > 127) || (s < -128);
      end
      4'd4:  begin res = 8'(a & b);  m = 5'b01110; end
      4'd5:  begin res = 8'(a | b);  m = 5'b01110; end
      4'd6:  begin res = 8'(a ^ b);  m = 5'b01110; end
      4'd14: begin res = 8'(a & ~b); m = 5'b01110; end
      4'd7:  begin res = 8'(255 - a); m = 5'b01111; nf[0] = 1'b1; end
      4'd13: begin res = 8'hFF; m = 5'b00000; end
      default: begin wr = 1'b0; m = 5'b00000; end
    endcase
    nf[1] = (res == 8'h00) && (!chain || f[1]);
    nf[2] = res[7];
  endtask

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic run_op(input logic [3:0] o, input logic [7:0] a, input logic [7:0] b,
                        input logic iss = 1'b1);
    logic [7:0] er; logic ew; logic [4:0] em, ef;
    string rq;
    @(negedge clk);
    op = o; opnd_a = a; opnd_b = b; issue = iss;
    #5;
    model(o, int'(a), int'(b), mflags, er, ew, em, ef);
    rq = req_of(o);
    if (ew) check(rq, "result", int'(result), int'(er));
    check(rq, "wr_en", int'(wr_en), int'(ew));
    check(rq, "flag_mask", int'(flag_mask), int'(em));
    check(rq, "flag_next", int'(flag_next & em), int'(ef & em));
    @(posedge clk); #1;
    if (iss) mflags = (mflags & ~em) | (ef & em);
    check(iss ? rq : "R11", "flags", int'(flags), int'(mflags));
    issue = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234ABCD));
    repeat (3) @(posedge clk);
    #1;
    check("R1", "reset flags", int'(flags), 0);
    rst_n = 1'b1;

    // R2 add corners: signed overflow with half carry, then wrap to zero
    run_op(4'd0, 8'h7F, 8'h01);
    run_op(4'd0, 8'hFF, 8'h01);
    run_op(4'd1, 8'h10, 8'h20);          // R2 adds C=1
    // R3 subtract borrow
    run_op(4'd2, 8'h00, 8'h01);
    run_op(4'd3, 8'h05, 8'h04);          // R3 subtracts C=1 -> zero, R4 Z chained from 0
    // R4 multi-byte compare chain
    run_op(4'd11, 8'h34, 8'h34);         // R9 Z=1, C=0
    run_op(4'd12, 8'h12, 8'h12);         // R4 Z stays 1
    run_op(4'd12, 8'h13, 8'h12);         // Z clears
    run_op(4'd12, 8'h00, 8'h00);         // R4 Z must stay 0
    // R5 logic keeps C,H
    run_op(4'd2, 8'h10, 8'h01);          // sets C=0,H=1
    run_op(4'd2, 8'h00, 8'h01);          // sets C=1,H=1
    run_op(4'd4, 8'hF0, 8'h0F);
    run_op(4'd14, 8'hFF, 8'hF0);
    run_op(4'd6, 8'h80, 8'h00);
    // R6 / R7
    run_op(4'd7, 8'hFF, 8'h00);
    run_op(4'd8, 8'h80, 8'h00);
    run_op(4'd8, 8'h00, 8'h00);
    // R8
    run_op(4'd9, 8'h7F, 8'h00);
    run_op(4'd10, 8'h80, 8'h00);
    run_op(4'd10, 8'h01, 8'h00);
    // R10, R12
    run_op(4'd13, 8'h00, 8'h00);
    run_op(4'd15, 8'h12, 8'h34);
    // R11 no issue -> flags unchanged
    run_op(4'd0, 8'hFF, 8'hFF, 1'b0);

    for (int i = 0; i < 3000; i++) begin
      logic [3:0] o; logic [7:0] a, b;
      o = 4'($urandom_range(0, 15));
      a = 8'($urandom);
      b = ($urandom_range(0, 7) == 0) ? a : 8'($urandom);
      run_op(o, a, b, ($urandom_range(0, 9) != 0));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule